// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second operand of a 32-bit data-processing datapath and the carry that goes with it. A value is shifted left or right (logically or arithmetically) or rotated, by an amount that comes either from a 5-bit immediate field or from the low byte of a register. Besides the shifted value, the block produces the bit shifted out last. The ALU uses that bit as the carry flag for logical operations.

A separate constant mode builds the operand from a 12-bit immediate. The low 8 bits are an unsigned constant. It is rotated right by twice the 4-bit count held in the top bits. In the immediate form, an amount of zero does not mean "no shift" for every shift kind: it encodes a full-width shift or a one-bit rotate through the incoming carry. The block is purely combinational.

Top module: `opnd_shifter`

## Requirements
- R1: `i_kind` selects the operation as 0 = logical left, 1 = logical right, 2 = arithmetic right (sign fill), 3 = rotate right. With `i_amt_is_reg` = 0 and a nonzero amount n = `i_amount[4:0]`, `o_value` is the input shifted or rotated by n.
- R2: With a nonzero immediate amount n, `o_carry` is input bit 32-n for logical left, and input bit n-1 for logical right, arithmetic right and rotate right.
- R3: An immediate logical-left amount of 0 gives `o_value` = `i_value` and `o_carry` = `i_carry`.
- R4: An immediate logical-right amount of 0 acts as a shift by 32. `o_value` = 0 and `o_carry` = input bit 31.
- R5: An immediate arithmetic-right amount of 0 acts as a shift by 32. `o_value` is input bit 31 copied into all 32 bits and `o_carry` = input bit 31.
- R6: An immediate rotate-right amount of 0 rotates right by one through the carry. `i_carry` enters bit 31, bits 31:1 move down by one, and `o_carry` = old bit 0.
- R7: In the immediate form, `i_amount[7:5]` has no effect. In the register form, all 8 bits of `i_amount` count, and an amount of 0 passes the value and the carry through unchanged.
- R8: With a register amount of 32, logical left gives 0 with carry = input bit 0, and logical right gives 0 with carry = input bit 31. With any register amount above 32, both give 0 with carry 0.
- R9: With a register amount of 32 or more, arithmetic right gives the sign fill and carry = input bit 31.
- R10: With a nonzero register amount, rotate right uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged and gives carry = input bit 31.
- R11: With `i_const_mode` = 1, `o_value` is `i_const[7:0]` zero-extended and rotated right by 2 x `i_const[11:8]`. In this mode `i_value`, `i_kind`, `i_amount` and `i_amt_is_reg` have no effect.
- R12: In constant mode, `o_carry` = `i_carry` when `i_const[11:8]` = 0, and is bit 31 of `o_value` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_value | input | 32 | Value to shift |
| i_kind | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| i_amount | input | 8 | Shift amount: bits 4:0 in the immediate form, all 8 bits in the register form |
| i_amt_is_reg | input | 1 | 1 = amount comes from a register byte |
| i_carry | input | 1 | Current carry flag |
| i_const_mode | input | 1 | 1 = build the operand from `i_const` |
| i_const | input | 12 | Rotate count in bits 11:8, constant in bits 7:0 |
| o_value | output | 32 | Shifted operand |
| o_carry | output | 1 | Shifter carry-out |

## Verification
The assertions in the bound checker watch, on every input change, the zero-amount immediate encodings (pass-through, the full-width shifts, the rotate through carry), pass-through for a zero register amount, and the zeroing of logical shifts above 32. They also check that rotations keep the count of set bits, both in the register form and in constant mode. The exact carry position for each nonzero amount, the rotate-modulo values, and the fact that unused inputs have no effect can only be shown by the bench. The bench compares every output against a bit-by-bit model over directed corner amounts (0, 1, 31, 32, 33, 255) and thousands of random cases.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

    localparam int OPSH_WIDTH   = 32;
    localparam int OPSH_AMT_W   = 8;
    localparam int OPSH_CONST_W = 12;

    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        CORE_PASS = 3'd0,
        CORE_LSL  = 3'd1,
        CORE_LSR  = 3'd2,
        CORE_ASR  = 3'd3,
        CORE_ROR  = 3'd4,
        CORE_RRX  = 3'd5
    } core_op_e;

    // Canonical request handed to the shift core; amt ranges 0..WIDTH+1,
    // where WIDTH+1 stands for "further than the full width".
    typedef struct packed {
        core_op_e              op;
        logic [OPSH_AMT_W-1:0] amt;
    } core_req_t;

    function automatic logic [OPSH_AMT_W-1:0] clamp_amt(
        input logic [OPSH_AMT_W-1:0] raw,
        input logic [OPSH_AMT_W-1:0] limit
    );
        return (raw > limit) ? limit : raw;
    endfunction

endpackage

// File: rtl/opsh_constgen.sv
module opsh_constgen
    import opsh_pkg::*;
#(
    parameter int WIDTH   = OPSH_WIDTH,
    parameter int CONST_W = OPSH_CONST_W,
    parameter int AMT_W   = OPSH_AMT_W
) (
    input  logic [CONST_W-1:0] const_i,
    output logic [WIDTH-1:0]   base_o,
    output logic [AMT_W-1:0]   rot_o
);
    localparam int BYTE_W = 8;
    localparam int ROT_W  = CONST_W - BYTE_W;

    logic [ROT_W-1:0] rot_field;

    always_comb begin
        rot_field = const_i[CONST_W-1:BYTE_W];
        base_o    = {{(WIDTH-BYTE_W){1'b0}}, const_i[BYTE_W-1:0]};
        rot_o     = AMT_W'({rot_field, 1'b0});
    end
endmodule

// File: rtl/opsh_decode.sv
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int WIDTH = OPSH_WIDTH,
    parameter int AMT_W = OPSH_AMT_W
) (
    input  logic [WIDTH-1:0] value_i,
    input  shift_kind_e      kind_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             is_reg_i,
    input  logic             const_mode_i,
    input  logic [WIDTH-1:0] const_base_i,
    input  logic [AMT_W-1:0] const_rot_i,
    output logic [WIDTH-1:0] operand_o,
    output core_req_t        req_o
);
    localparam int SH_W = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);
    localparam logic [AMT_W-1:0] OVER = AMT_W'(WIDTH + 1);

    logic [SH_W-1:0]  imm_amt;
    logic [AMT_W-1:0] imm_ext;
    logic [SH_W-1:0]  reg_low;

    always_comb begin
        imm_amt   = amount_i[SH_W-1:0];
        imm_ext   = AMT_W'(imm_amt);
        reg_low   = amount_i[SH_W-1:0];
        operand_o = value_i;
        req_o     = '{op: CORE_PASS, amt: '0};

        if (const_mode_i) begin
            operand_o = const_base_i;
            req_o.op  = (const_rot_i == '0) ? CORE_PASS : CORE_ROR;
            req_o.amt = const_rot_i;
        end else if (!is_reg_i) begin
            unique case (kind_i)
                SHK_LSL: begin
                    req_o.op  = (imm_amt == '0) ? CORE_PASS : CORE_LSL;
                    req_o.amt = imm_ext;
                end
                SHK_LSR: begin
                    req_o.op  = CORE_LSR;
                    req_o.amt = (imm_amt == '0) ? FULL : imm_ext;
                end
                SHK_ASR: begin
                    req_o.op  = CORE_ASR;
                    req_o.amt = (imm_amt == '0) ? FULL : imm_ext;
                end
                default: begin
                    req_o.op  = (imm_amt == '0) ? CORE_RRX : CORE_ROR;
                    req_o.amt = imm_ext;
                end
            endcase
        end else if (amount_i != '0) begin
            unique case (kind_i)
                SHK_LSL: begin
                    req_o.op  = CORE_LSL;
                    req_o.amt = clamp_amt(amount_i, OVER);
                end
                SHK_LSR: begin
                    req_o.op  = CORE_LSR;
                    req_o.amt = clamp_amt(amount_i, OVER);
                end
                SHK_ASR: begin
                    req_o.op  = CORE_ASR;
                    req_o.amt = clamp_amt(amount_i, FULL);
                end
                default: begin
                    req_o.op  = CORE_ROR;
                    req_o.amt = (reg_low == '0) ? FULL : AMT_W'(reg_low);
                end
            endcase
        end
    end
endmodule

// File: rtl/opsh_core.sv
module opsh_core
    import opsh_pkg::*;
#(
    parameter int WIDTH = OPSH_WIDTH,
    parameter int AMT_W = OPSH_AMT_W
) (
    input  logic [WIDTH-1:0] operand_i,
    input  core_req_t        req_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] value_o,
    output logic             carry_o
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]        lsl_w;
    logic [DW-1:0]        lsr_w;
    logic signed [DW-1:0] asr_w;
    logic [DW-1:0]        ror_w;

    // Each double-width result holds the shifted value in one half and the
    // last bit pushed out right next to it, so the carry needs no index math.
    always_comb begin
        lsl_w = {{WIDTH{1'b0}}, operand_i} << req_i.amt;
        lsr_w = {operand_i, {WIDTH{1'b0}}} >> req_i.amt;
        asr_w = $signed({operand_i, {WIDTH{1'b0}}}) >>> req_i.amt;
        ror_w = {operand_i, operand_i} >> req_i.amt;

        value_o = operand_i;
        carry_o = carry_i;
        unique case (req_i.op)
            CORE_LSL: begin
                value_o = lsl_w[WIDTH-1:0];
                carry_o = lsl_w[WIDTH];
            end
            CORE_LSR: begin
                value_o = lsr_w[DW-1:WIDTH];
                carry_o = lsr_w[WIDTH-1];
            end
            CORE_ASR: begin
                value_o = asr_w[DW-1:WIDTH];
                carry_o = asr_w[WIDTH-1];
            end
            CORE_ROR: begin
                value_o = ror_w[WIDTH-1:0];
                carry_o = ror_w[WIDTH-1];
            end
            CORE_RRX: begin
                value_o = {carry_i, operand_i[WIDTH-1:1]};
                carry_o = operand_i[0];
            end
            default: begin
                value_o = operand_i;
                carry_o = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opsh_pkg::*;
#(
    parameter int WIDTH   = OPSH_WIDTH,
    parameter int AMT_W   = OPSH_AMT_W,
    parameter int CONST_W = OPSH_CONST_W
) (
    input  logic [WIDTH-1:0]   i_value,
    input  logic [1:0]         i_kind,
    input  logic [AMT_W-1:0]   i_amount,
    input  logic               i_amt_is_reg,
    input  logic               i_carry,
    input  logic               i_const_mode,
    input  logic [CONST_W-1:0] i_const,
    output logic [WIDTH-1:0]   o_value,
    output logic               o_carry
);
    logic [WIDTH-1:0] const_base;
    logic [AMT_W-1:0] const_rot;
    logic [WIDTH-1:0] core_operand;
    core_req_t        core_req;

    opsh_constgen #(.WIDTH(WIDTH), .CONST_W(CONST_W), .AMT_W(AMT_W)) u_constgen (
        .const_i (i_const),
        .base_o  (const_base),
        .rot_o   (const_rot)
    );

    opsh_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_decode (
        .value_i      (i_value),
        .kind_i       (shift_kind_e'(i_kind)),
        .amount_i     (i_amount),
        .is_reg_i     (i_amt_is_reg),
        .const_mode_i (i_const_mode),
        .const_base_i (const_base),
        .const_rot_i  (const_rot),
        .operand_o    (core_operand),
        .req_o        (core_req)
    );

    opsh_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
        .operand_i (core_operand),
        .req_i     (core_req),
        .carry_i   (i_carry),
        .value_o   (o_value),
        .carry_o   (o_carry)
    );
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
    parameter int WIDTH   = 32,
    parameter int AMT_W   = 8,
    parameter int CONST_W = 12
) (
    input logic [WIDTH-1:0]   i_value,
    input logic [1:0]         i_kind,
    input logic [AMT_W-1:0]   i_amount,
    input logic               i_amt_is_reg,
    input logic               i_carry,
    input logic               i_const_mode,
    input logic [CONST_W-1:0] i_const,
    input logic [WIDTH-1:0]   o_value,
    input logic               o_carry
);
    localparam int SH_W = $clog2(WIDTH);

    logic imm_zero;
    logic known;

    always_comb begin
        imm_zero = (i_amount[SH_W-1:0] == '0);
        known    = !$isunknown({i_value, i_kind, i_amount, i_amt_is_reg,
                                i_carry, i_const_mode, i_const});
        if (known && !i_const_mode && !i_amt_is_reg && imm_zero) begin
            if (i_kind == 2'd0)
                AST_IMM_LSL_ZERO_PASS: assert (o_value == i_value && o_carry == i_carry); // R3
            if (i_kind == 2'd1)
                AST_IMM_LSR_FULL_WIDTH: assert (o_value == '0 && o_carry == i_value[WIDTH-1]); // R4
            if (i_kind == 2'd2)
                AST_IMM_ASR_SIGN_FILL: assert (o_value == {WIDTH{i_value[WIDTH-1]}} && o_carry == i_value[WIDTH-1]); // R5
            if (i_kind == 2'd3)
                AST_IMM_ROR_THROUGH_CARRY: assert (o_value[WIDTH-1] == i_carry && o_value[WIDTH-2:0] == i_value[WIDTH-1:1] && o_carry == i_value[0]); // R6
        end
        if (known && !i_const_mode && i_amt_is_reg && i_amount == '0)
            AST_REG_ZERO_PASS: assert (o_value == i_value && o_carry == i_carry); // R7
        if (known && !i_const_mode && i_amt_is_reg && i_amount > AMT_W'(WIDTH) && i_kind[1] == 1'b0)
            AST_REG_LOGIC_BEYOND: assert (o_value == '0 && o_carry == 1'b0); // R8
        if (known && !i_const_mode && i_amt_is_reg && i_kind == 2'd3)
            AST_REG_ROR_KEEPS_BITS: assert ($countones(o_value) == $countones(i_value)); // R10
        if (known && i_const_mode)
            AST_CONST_KEEPS_BITS: assert ($countones(o_value) == $countones(i_const[7:0])); // R11
    end
endmodule

bind opnd_shifter opnd_shifter_chk #(
    .WIDTH(WIDTH), .AMT_W(AMT_W), .CONST_W(CONST_W)
) u_chk (
    .i_value      (i_value),
    .i_kind       (i_kind),
    .i_amount     (i_amount),
    .i_amt_is_reg (i_amt_is_reg),
    .i_carry      (i_carry),
    .i_const_mode (i_const_mode),
    .i_const      (i_const),
    .o_value      (o_value),
    .o_carry      (o_carry)
);

// File: tb/opnd_shifter_tb_top.sv
module opnd_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] i_value;
    logic [1:0]  i_kind;
    logic [7:0]  i_amount;
    logic        i_amt_is_reg;
    logic        i_carry;
    logic        i_const_mode;
    logic [11:0] i_const;
    logic [31:0] o_value;
    logic        o_carry;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    opnd_shifter dut_i (
        .i_value      (i_value),
        .i_kind       (i_kind),
        .i_amount     (i_amount),
        .i_amt_is_reg (i_amt_is_reg),
        .i_carry      (i_carry),
        .i_const_mode (i_const_mode),
        .i_const      (i_const),
        .o_value      (o_value),
        .o_carry      (o_carry)
    );

    // Bit-by-bit reference: one single-step move per unit of amount.
    function automatic logic [32:0] model(
        input logic [31:0] v, input logic [1:0] k, input logic [7:0] a,
        input logic isreg, input logic cin, input logic cm, input logic [11:0] cst
    );
        logic [31:0] x = v;
        logic        c = cin;
        int          n;
        if (cm) begin
            x = {24'd0, cst[7:0]};
            for (int i = 0; i < 2 * int'(cst[11:8]); i++) begin
                c = x[0];
                x = {x[0], x[31:1]};
            end
            return {c, x};
        end
        n = isreg ? int'(a) : int'(a[4:0]);
        if (!isreg && n == 0) begin
            if (k == 2'd0) return {cin, v};
            if (k == 2'd3) return {v[0], cin, v[31:1]};
            n = 32;
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin c = x[31]; x = {x[30:0], 1'b0}; end
                2'd1: begin c = x[0];  x = {1'b0, x[31:1]}; end
                2'd2: begin c = x[0];  x = {x[31], x[31:1]}; end
                default: begin c = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {c, x};
    endfunction

    task automatic apply_check(
        input string req, input logic [31:0] v, input logic [1:0] k,
        input logic [7:0] a, input logic isreg, input logic cin,
        input logic cm, input logic [11:0] cst
    );
        logic [32:0] exp;
        @(negedge clk);
        i_value = v; i_kind = k; i_amount = a; i_amt_is_reg = isreg;
        i_carry = cin; i_const_mode = cm; i_const = cst;
        exp = model(v, k, a, isreg, cin, cm, cst);
        @(posedge clk);
        #1;
        n_checks++;
        if ({o_carry, o_value} !== exp) begin
            n_fails++;
            $display("FAIL %s: kind=%0d amt=%0d reg=%0b const=%0b in=%h cin=%0b -> got c=%0b v=%h, exp c=%0b v=%h",
                     req, k, a, isreg, cm, v, cin, o_carry, o_value, exp[32], exp[31:0]);
        end
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] pats [4];
        seed = 32'd20240611;
        void'($urandom(seed));
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96; pats[3] = 32'hFFFF_FFFF;

        i_value = '0; i_kind = '0; i_amount = '0; i_amt_is_reg = 0;
        i_carry = 0; i_const_mode = 0; i_const = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Quiet state: all inputs zero gives zero output and zero carry
        apply_check("R3", 32'h0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 12'h0);

        foreach (pats[p]) begin
            for (int k = 0; k < 4; k++) begin
                for (int c = 0; c < 2; c++) begin
                    // R1 R2: nonzero immediate amounts at the edges
                    apply_check("R1", pats[p], 2'(k), 8'd1,  1'b0, 1'(c), 1'b0, 12'h0);
                    apply_check("R2", pats[p], 2'(k), 8'd31, 1'b0, 1'(c), 1'b0, 12'h0);
                    apply_check("R2", pats[p], 2'(k), 8'd13, 1'b0, 1'(c), 1'b0, 12'h0);
                    // R3 R4 R5 R6: immediate amount zero per kind
                    apply_check(k == 0 ? "R3" : k == 1 ? "R4" : k == 2 ? "R5" : "R6",
                                pats[p], 2'(k), 8'd0, 1'b0, 1'(c), 1'b0, 12'h0);
                    // R7: upper amount bits ignored in immediate form
                    apply_check("R7", pats[p], 2'(k), 8'hE0, 1'b0, 1'(c), 1'b0, 12'h0);
                    apply_check("R7", pats[p], 2'(k), 8'hA5, 1'b0, 1'(c), 1'b0, 12'h0);
                    // R7: register amount zero passes through
                    apply_check("R7", pats[p], 2'(k), 8'd0, 1'b1, 1'(c), 1'b0, 12'h0);
                    // R8 R9 R10: register amounts at and past the width
                    apply_check(k[1] ? (k == 2 ? "R9" : "R10") : "R8", pats[p], 2'(k), 8'd32,  1'b1, 1'(c), 1'b0, 12'h0);
                    apply_check(k[1] ? (k == 2 ? "R9" : "R10") : "R8", pats[p], 2'(k), 8'd33,  1'b1, 1'(c), 1'b0, 12'h0);
                    apply_check(k[1] ? (k == 2 ? "R9" : "R10") : "R8", pats[p], 2'(k), 8'd255, 1'b1, 1'(c), 1'b0, 12'h0);
                    apply_check(k[1] ? (k == 2 ? "R9" : "R10") : "R8", pats[p], 2'(k), 8'd64,  1'b1, 1'(c), 1'b0, 12'h0);
                    apply_check("R10", pats[p], 2'(k), 8'd40, 1'b1, 1'(c), 1'b0, 12'h0);
                end
            end
        end

        // R11 R12: constant mode, rotate zero and nonzero, unrelated inputs varied
        for (int r = 0; r < 16; r++) begin
            apply_check("R11", 32'hDEAD_BEEF, 2'd2, 8'd7, 1'b1, 1'b1, 1'b1, {4'(r), 8'hB1});
            apply_check("R12", 32'h1234_5678, 2'd0, 8'd0, 1'b0, 1'b0, 1'b1, {4'(r), 8'h81});
            apply_check("R12", 32'h0,         2'd3, 8'd3, 1'b0, 1'b1, 1'b1, {4'(r), 8'h00});
        end

        // Random mix across every mode
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = $urandom();
            if (i % 5 == 0) a = 8'(28 + ($urandom() % 8));
            apply_check((i % 7 == 0) ? "R11" : "R1", $urandom(), 2'($urandom()), a,
                        1'($urandom()), 1'($urandom()), (i % 7 == 0), 12'($urandom()));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule